// File: doc/BRIEF.md
# Cascadable Masked Interrupt Controller

This block gathers up to 32 interrupt inputs into one request line for a processor or for a parent controller. Each channel passes through an input mask and a capture stage. The capture stage works either on rising edges or on the level of the input, and it sets a sticky pending bit. An output enable then decides whether that pending bit may reach the aggregated request. The request is driven either as a level that follows the OR of the enabled pending bits, or as a pulse one clock long each time that OR goes from 0 to 1.

Software uses a small word-addressed register bus. It sets the mask, enable and capture-edge words, reads the pending word, and removes pending bits by writing ones to a clear word. The number of channels is set per instance. Controllers can be nested one level deep: the request output of a child drives one channel of a parent. A child's event therefore reaches the processor only when both the child channel and the parent channel carrying it are unmasked and enabled.

The bus takes one request per cycle and never stalls. `req_ready` does not exist and no back-pressure is applied. A read's data returns with `rsp_valid` in the cycle after the request. A write takes effect at the clock edge that accepts it, so any later read observes it. A read therefore acts as a write-completion fence.

Top module: `irq_hub`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is low. This means every channel is masked, disabled and in level capture, and the output is in level mode.
- R2: A channel whose mask bit (word address 0) is 0 never sets its pending bit, whatever its input does. A mask bit of 1 lets the input through.
- R3: When a channel's capture-edge bit (address 2) is 1, the pending bit is set only on a 0-to-1 transition of the input, so an input that is already high sets nothing. When the bit is 0, the pending bit is set in every cycle the input is high. In both modes the pending bit stays set after the input falls.
- R4: Writing to the clear word (address 3) clears exactly the pending bits written as 1. Bits written as 0 leave the other channels' pending bits unchanged.
- R5: If a channel's set condition and a clear write for that channel occur in the same cycle, the pending bit ends up set.
- R6: A pending bit whose enable bit (address 1) is 0 does not drive `irq_out`. It can still be read in the pending word (address 4).
- R7: In level mode (bit 0 of the output-mode word at address 5 is 0), `irq_out` equals the OR of the pending bits ANDed with their enable bits.
- R8: In pulse mode (output-mode bit 0 is 1), `irq_out` is high for exactly one cycle each time that OR rises from 0 to 1. A further channel becoming pending while the OR is already 1 gives no new pulse. The output-mode word reads back as all implemented bits set when in pulse mode.
- R9: Bits at or above `NUM_CH` read as 0 in every register, and writes to them are ignored. Writes to the pending word and to unused addresses 6 and 7 change nothing, and those addresses read as 0.
- R10: A read returns its data with `rsp_valid` one cycle after the request. The data reflects every write accepted in an earlier cycle.
- R11: When a child's `irq_out` feeds a parent channel, an event on a child channel sets the parent pending bit and raises the parent `irq_out` only if both levels are unmasked and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_CH | Interrupt inputs, one per channel |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 1 | Aggregated interrupt request (level or pulse) |

## Verification
The bench sweeps every channel of an 8-channel instance through all eight combinations of mask, capture edge and enable.

- It holds the input high across the configuration writes. A controller that treated a held-high level as an edge would show a pending bit in edge mode, and one that ignored the mask would set bits it must not.
- It makes a clear write collide with a fresh rising edge. A design that let the clear win would lose that event.
- It raises a second channel while a pulse-mode request is already pending. A design that pulsed on each new pending bit, or held the pulse, would show up there.
- It nests three 4-channel children under the parent. An event must cross both levels only when both channels are open.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MASK    = 3'd0,
    RA_ENABLE  = 3'd1,
    RA_EDGE    = 3'd2,
    RA_CLEAR   = 3'd3,
    RA_PENDING = 3'd4,
    RA_OUTMODE = 3'd5
  } reg_addr_e;

  function automatic logic [DATA_W-1:0] live_bits(input int n);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = (i < n);
    return r;
  endfunction
endpackage

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] pending,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] enable,
  output logic [DATA_W-1:0] edge_sel,
  output logic [DATA_W-1:0] clr_bits,
  output logic              pulse_mode,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [DATA_W-1:0] LIVE = live_bits(NUM_CH);

  logic              wr_en;
  logic [DATA_W-1:0] wdata_live;
  logic [DATA_W-1:0] rd_mux;
  reg_addr_e         sel;

  assign sel        = reg_addr_e'(req_addr);
  assign wr_en      = req_valid && req_write;
  assign wdata_live = req_wdata & LIVE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask       <= '0;
      enable     <= '0;
      edge_sel   <= '0;
      pulse_mode <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        RA_MASK:    mask       <= wdata_live;
        RA_ENABLE:  enable     <= wdata_live;
        RA_EDGE:    edge_sel   <= wdata_live;
        RA_OUTMODE: pulse_mode <= req_wdata[0];
        default:    ;
      endcase
    end
  end

  // clear strobe lasts only for the accepting cycle
  assign clr_bits = (wr_en && sel == RA_CLEAR) ? wdata_live : '0;

  always_comb begin
    case (sel)
      RA_MASK:    rd_mux = mask;
      RA_ENABLE:  rd_mux = enable;
      RA_EDGE:    rd_mux = edge_sel;
      RA_PENDING: rd_mux = pending;
      RA_OUTMODE: rd_mux = pulse_mode ? LIVE : '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irq_hub_capture.sv
module irq_hub_capture
  import irq_hub_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] irq_vec,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] edge_sel,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] pending
);
  localparam logic [DATA_W-1:0] LIVE = live_bits(NUM_CH);

  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] hit;
  logic [DATA_W-1:0] pend_d;

  assign rise   = irq_vec & ~prev_q;
  assign hit    = mask & ((edge_sel & rise) | (~edge_sel & irq_vec));
  // new event ORed after the clear so a colliding clear cannot drop it
  assign pend_d = ((pending & ~clr_bits) | hit) & LIVE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pending <= '0;
    end else begin
      prev_q  <= irq_vec & LIVE;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/irq_hub_out.sv
module irq_hub_out
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pending,
  input  logic [DATA_W-1:0] enable,
  input  logic              pulse_mode,
  output logic              irq_out
);
  logic any_now;
  logic any_q;

  assign any_now = |(pending & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= any_now;
  end

  assign irq_out = pulse_mode ? (any_now && !any_q) : any_now;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_out
);
  logic [DATA_W-1:0] irq_vec;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] edge_q;
  logic [DATA_W-1:0] clr_bits;
  logic [DATA_W-1:0] pend_q;
  logic              pulse_mode;

  assign irq_vec = DATA_W'(irq_in);

  irq_hub_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .pending(pend_q),
    .mask(mask_q), .enable(enable_q), .edge_sel(edge_q),
    .clr_bits(clr_bits), .pulse_mode(pulse_mode),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  irq_hub_capture #(.NUM_CH(NUM_CH)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .irq_vec(irq_vec), .mask(mask_q), .edge_sel(edge_q),
    .clr_bits(clr_bits), .pending(pend_q)
  );

  irq_hub_out u_out (
    .clk(clk), .rst_n(rst_n),
    .pending(pend_q), .enable(enable_q),
    .pulse_mode(pulse_mode), .irq_out(irq_out)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              irq_out,
  input logic [DATA_W-1:0] pend_q,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] enable_q,
  input logic              pulse_mode
);
  logic [DATA_W-1:0] clr_word;
  assign clr_word = (req_valid && req_write && req_addr == RA_CLEAR) ? req_wdata : '0;

  // R2: a pending bit can only rise where the mask was open
  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(mask_q)) == '0);

  // R4: a pending bit can only fall where a clear was written
  a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q) & ~$past(clr_word)) == '0);

  // R7: level-mode output tracks enabled pending bits
  a_r7_level_out: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_mode |-> (irq_out == |(pend_q & enable_q)));

  // R8: a pulse never lasts two cycles in pulse mode
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && irq_out) |=> (!irq_out || !pulse_mode));

  // R9: no read returns bits above the channel count
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~live_bits(NUM_CH)) == '0));

  // R10: a response follows a read request by one cycle
  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

bind irq_hub irq_hub_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .irq_out(irq_out), .pend_q(pend_q), .mask_q(mask_q),
  .enable_q(enable_q), .pulse_mode(pulse_mode)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  import irq_hub_pkg::*;
  localparam int P_CH = 8;
  localparam int K_CH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]        rv = '0;
  logic              rw = 1'b0;
  logic [2:0]        ra = '0;
  logic [31:0]       wd = '0;
  logic [3:0]        rsv;
  logic [3:0][31:0]  rd;
  logic [3:0]        iout;
  logic [7:0]        p_in = '0;
  logic [2:0][3:0]   k_in = '0;
  logic [7:0]        p_irq;

  int n_chk = 0;
  int n_fail = 0;

  assign p_irq = p_in | {iout[3:1], 5'b0};

  irq_hub #(.NUM_CH(P_CH)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(p_irq),
    .req_valid(rv[0]), .req_write(rw), .req_addr(ra), .req_wdata(wd),
    .rsp_valid(rsv[0]), .rsp_rdata(rd[0]), .irq_out(iout[0])
  );

  for (genvar k = 1; k < 4; k++) begin : g_kid
    irq_hub #(.NUM_CH(K_CH)) u_kid (
      .clk(clk), .rst_n(rst_n), .irq_in(k_in[k-1]),
      .req_valid(rv[k]), .req_write(rw), .req_addr(ra), .req_wdata(wd),
      .rsp_valid(rsv[k]), .rsp_rdata(rd[k]), .irq_out(iout[k])
    );
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int k, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    rv[k] = 1'b1; rw = 1'b1; ra = a; wd = d;
    @(negedge clk);
    rv[k] = 1'b0; rw = 1'b0;
  endtask

  task automatic rdr(input int k, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rv[k] = 1'b1; rw = 1'b0; ra = a;
    @(negedge clk);
    rv[k] = 1'b0;
    chk("R10 rsp_valid", 32'(rsv[k]), 32'd1);
    d = rd[k];
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog got=timeout exp=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq_out", 32'(iout[0]), 32'd0);
    for (int a = 0; a < 8; a++) begin
      rdr(0, 3'(a), v);
      chk("R1 reg", v, 32'd0);
    end

    // R10 fence: write then immediately read back
    wr(0, RA_ENABLE, 32'h0000_005A);
    rdr(0, RA_ENABLE, v);
    chk("R10 fence", v, 32'h5A);
    wr(0, RA_ENABLE, 32'h0);

    // R9: unimplemented bits and read-only addresses
    wr(0, RA_MASK, 32'hFFFF_FFFF);
    rdr(0, RA_MASK, v);
    chk("R9 mask upper", v, 32'hFF);
    wr(0, RA_MASK, 32'h0);
    wr(0, RA_PENDING, 32'hFFFF_FFFF);
    rdr(0, RA_PENDING, v);
    chk("R9 pending write", v, 32'h0);
    wr(0, 3'd6, 32'hFFFF_FFFF);
    rdr(0, 3'd6, v);
    chk("R9 addr6", v, 32'h0);
    wr(0, RA_OUTMODE, 32'hFFFF_FFFF);
    rdr(0, RA_OUTMODE, v);
    chk("R8 mode readback", v, 32'hFF);
    wr(0, RA_OUTMODE, 32'h0);

    // sweep: channel x {mask, edge, enable}
    for (int ch = 0; ch < P_CH; ch++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        logic m, e, en;
        m = cfg[0]; e = cfg[1]; en = cfg[2];
        p_in = 8'(1 << ch);
        wr(0, RA_EDGE,   32'(e)  << ch);
        wr(0, RA_ENABLE, 32'(en) << ch);
        wr(0, RA_MASK,   32'(m)  << ch);
        wr(0, RA_CLEAR,  32'hFF);
        rdr(0, RA_PENDING, v);
        chk("R3 held-high", v, 32'(m & ~e) << ch);
        chk("R6 out", 32'(iout[0]), 32'(m & ~e & en));
        p_in = '0;
        wr(0, RA_CLEAR, 32'hFF);
        rdr(0, RA_PENDING, v);
        chk("R4 cleared", v, 32'h0);
        @(negedge clk);
        p_in = 8'(1 << ch);
        @(negedge clk);
        p_in = '0;
        rdr(0, RA_PENDING, v);
        chk("R2 one-cycle event", v, 32'(m) << ch);
        chk("R7 out", 32'(iout[0]), 32'(m & en));
        wr(0, RA_CLEAR, 32'hFF);
        wr(0, RA_MASK, 32'h0);
        wr(0, RA_ENABLE, 32'h0);
        wr(0, RA_EDGE, 32'h0);
      end
    end

    // R4: selective clear
    wr(0, RA_EDGE, 32'hFF);
    wr(0, RA_MASK, 32'hFF);
    @(negedge clk);
    p_in = 8'h4A;
    @(negedge clk);
    p_in = 8'h00;
    wr(0, RA_CLEAR, 32'h08);
    rdr(0, RA_PENDING, v);
    chk("R4 selective", v, 32'h42);

    // R5: clear collides with a fresh rising edge
    wr(0, RA_CLEAR, 32'hFF);
    @(negedge clk);
    rv[0] = 1'b1; rw = 1'b1; ra = RA_CLEAR; wd = 32'h02;
    p_in = 8'h02;
    @(negedge clk);
    rv[0] = 1'b0; rw = 1'b0; p_in = 8'h00;
    rdr(0, RA_PENDING, v);
    chk("R5 set wins", v, 32'h02);

    // R8: pulse mode
    wr(0, RA_CLEAR, 32'hFF);
    wr(0, RA_ENABLE, 32'hFF);
    wr(0, RA_OUTMODE, 32'hFFFF_FFFF);
    chk("R8 idle", 32'(iout[0]), 32'd0);
    p_in = 8'h01;
    @(negedge clk);
    p_in = 8'h00;
    chk("R8 pulse high", 32'(iout[0]), 32'd1);
    @(negedge clk);
    chk("R8 pulse low", 32'(iout[0]), 32'd0);
    p_in = 8'h04;
    @(negedge clk);
    p_in = 8'h00;
    chk("R8 no repulse", 32'(iout[0]), 32'd0);
    wr(0, RA_CLEAR, 32'hFF);
    p_in = 8'h01;
    @(negedge clk);
    p_in = 8'h00;
    chk("R8 second pulse", 32'(iout[0]), 32'd1);
    wr(0, RA_OUTMODE, 32'h0);
    chk("R7 level again", 32'(iout[0]), 32'd1);
    wr(0, RA_CLEAR, 32'hFF);
    chk("R7 level low", 32'(iout[0]), 32'd0);
    wr(0, RA_MASK, 32'h0);
    wr(0, RA_ENABLE, 32'h0);
    wr(0, RA_EDGE, 32'h0);

    // R11: cascade, child 1 -> parent channel 5
    wr(0, RA_MASK, 32'h20);
    wr(0, RA_ENABLE, 32'h20);
    wr(1, RA_MASK, 32'h4);
    wr(1, RA_ENABLE, 32'h4);
    k_in[0] = 4'b0100;
    repeat (3) @(negedge clk);
    chk("R11 parent out", 32'(iout[0]), 32'd1);
    rdr(0, RA_PENDING, v);
    chk("R11 parent pending", v, 32'h20);
    rdr(1, RA_PENDING, v);
    chk("R11 child pending", v, 32'h4);
    k_in[0] = 4'b0000;
    wr(1, RA_CLEAR, 32'hF);
    wr(0, RA_CLEAR, 32'hFF);
    rdr(0, RA_PENDING, v);
    chk("R11 parent cleared", v, 32'h0);
    chk("R11 parent out low", 32'(iout[0]), 32'd0);
    // child 2 open, parent channel 6 closed
    wr(2, RA_MASK, 32'h2);
    wr(2, RA_ENABLE, 32'h2);
    k_in[1] = 4'b0010;
    repeat (3) @(negedge clk);
    chk("R11 child out", 32'(iout[2]), 32'd1);
    chk("R11 closed parent", 32'(iout[0]), 32'd0);
    rdr(0, RA_PENDING, v);
    chk("R11 parent not set", v, 32'h0);
    k_in[1] = 4'b0000;
    rdr(3, RA_MASK, v);
    chk("R1 child idle", v, 32'h0);

    summary();
  end
endmodule